// File: doc/BRIEF.md
# Single-Clock Gearbox FIFO

This block is a first-in first-out queue on one clock that changes the data width between its load side and its extract side. A mode parameter picks the direction. In packing mode, several narrow words are assembled into one wide word. In unpacking mode, each wide word is split back into narrow words. The ratio between the wide and narrow widths is a parameter from 1 to 8. The narrow width is `WIDE_W/RATIO`.

Entries are always held at the wide width, in a memory outside the block that has one write port and one read port. The block drives the strobes, addresses and write data of that memory and takes its read data back. An optional register stage on every memory signal raises the memory read latency from 1 cycle to 3 cycles. A small read-ahead buffer inside the block hides this latency. As a result, data at the extract port always follows an accepted extract request by exactly one clock in both configurations. The block provides three flags for flow control: full, almost-full and empty.

Top module: `gearbox_fifo`

## Requirements
- R1: While `rst_n` is low and right after it rises, `empty` is 1, `full` is 0 and `almost_full` is 0.
- R2: In packing mode (`UNPACK`=0), load k of a group (k = 0..RATIO-1) fills bits [k*NW +: NW] of the wide word. For example, byte loads AA, BB, CC, DD come out as 32'hDDCCBBAA.
- R3: In unpacking mode (`UNPACK`=1), the narrow words of one wide word come out lane 0 first (bits [NW-1:0]), followed by lanes 1, 2 and so on in rising order.
- R4: An extract is accepted when `rd_req` is 1 at a rising edge while `empty` is 0. The word it returns is on `rd_data` right after that edge, for `MEM_REG`=0 and for `MEM_REG`=1. Between accepted extracts, `rd_data` keeps its value.
- R5: In packing mode, a wide entry is written to memory only when its last lane is loaded. A partly packed group keeps `empty` at 1 and makes no memory write.
- R6: `full` is 1 exactly when DEPTH wide entries are held. An entry is released by the same edge that accepts its last narrow output in unpacking mode, or by the edge that accepts its extract in packing mode.
- R7: `almost_full` is 1 exactly when DEPTH minus the number of entries held is at most `AF_LEVEL`. The flag changes at the edge that adds or releases an entry.
- R8: A load while `full` is 1 is ignored. It makes no memory write, stores nothing and leaves the flags unchanged.
- R9: An extract while `empty` is 1 is ignored. `rd_data` and the flags keep their values.
- R10: The block issues a memory read only for an entry that has been written and not yet read. Read data never overflows the read-ahead buffer. `empty` falls within 10 cycles after an entry is completed on an otherwise empty queue.
- R11: `mem_we` pulses once per wide entry, and the write address steps through 0..DEPTH-1 cyclically. With `MEM_REG`=1, every memory output is delayed by one register, and `mem_rdata` is taken into a register before use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rst_n | input | 1 | Reset, active low |
| wr_req | input | 1 | Load request |
| wr_data | input | IN_W | Load data: NW bits when packing, WIDE_W bits when unpacking |
| rd_req | input | 1 | Extract request |
| rd_data | output | OUT_W | Extract data: WIDE_W bits when packing, NW bits when unpacking |
| full | output | 1 | No room for another wide entry |
| empty | output | 1 | No data ready to extract |
| almost_full | output | 1 | Free entries at or below AF_LEVEL |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | AW | Memory write address |
| mem_wdata | output | WIDE_W | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_raddr | output | AW | Memory read address |
| mem_rdata | input | WIDE_W | Memory read data |

## Verification
Wrong lane counters show up at the first extracted word as bytes in the wrong order. Wrong occupancy or pointer state shows up as `full` or `almost_full` changing on the wrong entry during a fill. It also shows up as data missing, repeated or extra when the queue is drained.

A mistake in the read-ahead accounting either leaves `empty` stuck after an entry completes, which a bounded wait detects within a few cycles, or duplicates or drops a word. A load that should have been ignored while full is caught by counting write strobes at the memory port and by checking the words that come out afterwards.

// File: rtl/gearbox_pkg.sv
package gearbox_pkg;
    // Width of an index over n items (at least one bit).
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a counter that must hold the value n.
    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/gbx_pack.sv
module gbx_pack
    import gearbox_pkg::*;
#(
    parameter int WIDE_W = 32,
    parameter int RATIO  = 4,
    localparam int NW    = WIDE_W / RATIO,
    localparam int LW    = idx_w(RATIO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [NW-1:0]     data_i,
    output logic              commit_o,
    output logic [WIDE_W-1:0] word_o
);
    typedef struct packed {
        logic [LW-1:0]     lane;
        logic [WIDE_W-1:0] acc;
    } pack_t;

    pack_t st_q, st_d;
    logic [WIDE_W-1:0] merged;

    always_comb begin
        st_d     = st_q;
        merged   = st_q.acc;
        merged[st_q.lane*NW +: NW] = data_i;
        commit_o = 1'b0;
        if (load_i) begin
            if (st_q.lane == LW'(RATIO - 1)) begin
                commit_o  = 1'b1;
                st_d.lane = '0;
                st_d.acc  = '0;
            end else begin
                st_d.lane = st_q.lane + LW'(1);
                st_d.acc  = merged;
            end
        end
    end

    assign word_o = merged;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the fill lane never passes the last lane of a group
    a_r2_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.lane) < RATIO);
endmodule

// File: rtl/gbx_unpack.sv
module gbx_unpack
    import gearbox_pkg::*;
#(
    parameter int WIDE_W = 32,
    parameter int RATIO  = 4,
    localparam int NW    = WIDE_W / RATIO,
    localparam int LW    = idx_w(RATIO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [WIDE_W-1:0] head_i,
    output logic              pop_o,
    output logic [NW-1:0]     lane_o
);
    typedef struct packed {
        logic [LW-1:0] lane;
    } unpack_t;

    unpack_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        pop_o  = 1'b0;
        lane_o = head_i[st_q.lane*NW +: NW];
        if (take_i) begin
            if (st_q.lane == LW'(RATIO - 1)) begin
                pop_o     = 1'b1;
                st_d.lane = '0;
            end else begin
                st_d.lane = st_q.lane + LW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the read lane stays inside one wide word
    a_r3_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.lane) < RATIO);
endmodule

// File: rtl/gbx_mem_port.sv
module gbx_mem_port
    import gearbox_pkg::*;
#(
    parameter int WIDE_W  = 32,
    parameter int AW      = 3,
    parameter bit MEM_REG = 1'b0,
    localparam int LAT    = MEM_REG ? 3 : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [WIDE_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [AW-1:0]     raddr_i,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [WIDE_W-1:0] mem_wdata,
    output logic              mem_re,
    output logic [AW-1:0]     mem_raddr,
    input  logic [WIDE_W-1:0] mem_rdata,
    output logic              rvalid_o,
    output logic [WIDE_W-1:0] rdata_o,
    output logic [1:0]        inflight_o
);
    // Valid pipe: one bit per read on its way back from memory.
    logic [LAT-1:0] vp_q, vp_d;

    always_comb begin
        vp_d       = LAT'({vp_q, re_i});
        inflight_o = '0;
        for (int i = 0; i < LAT; i++) begin
            inflight_o = inflight_o + 2'(vp_q[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vp_q <= '0;
        else        vp_q <= vp_d;
    end

    assign rvalid_o = vp_q[LAT-1];

    if (MEM_REG) begin : g_reg
        typedef struct packed {
            logic              we;
            logic [AW-1:0]     waddr;
            logic [WIDE_W-1:0] wdata;
            logic              re;
            logic [AW-1:0]     raddr;
            logic [WIDE_W-1:0] rdata;
        } stage_t;

        stage_t stg_q, stg_d;

        always_comb begin
            stg_d.we    = we_i;
            stg_d.waddr = waddr_i;
            stg_d.wdata = wdata_i;
            stg_d.re    = re_i;
            stg_d.raddr = raddr_i;
            stg_d.rdata = mem_rdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= '0;
            else        stg_q <= stg_d;
        end

        assign mem_we    = stg_q.we;
        assign mem_waddr = stg_q.waddr;
        assign mem_wdata = stg_q.wdata;
        assign mem_re    = stg_q.re;
        assign mem_raddr = stg_q.raddr;
        assign rdata_o   = stg_q.rdata;

        // R11: returned data lines up with a read issued three cycles before
        a_r11_return_lat3: assert property (@(posedge clk) disable iff (!rst_n)
            rvalid_o |-> $past(re_i, 3));
        // R11: the memory write strobe is the internal strobe one cycle late
        a_r11_we_delayed: assert property (@(posedge clk) disable iff (!rst_n)
            we_i |=> mem_we);
    end else begin : g_direct
        assign mem_we    = we_i;
        assign mem_waddr = waddr_i;
        assign mem_wdata = wdata_i;
        assign mem_re    = re_i;
        assign mem_raddr = raddr_i;
        assign rdata_o   = mem_rdata;

        // R11: returned data lines up with a read issued one cycle before
        a_r11_return_lat1: assert property (@(posedge clk) disable iff (!rst_n)
            rvalid_o |-> $past(re_i));
    end
endmodule

// File: rtl/gbx_prefetch.sv
module gbx_prefetch
    import gearbox_pkg::*;
#(
    parameter int WIDE_W  = 32,
    parameter int DEPTH_B = 2,
    localparam int PW     = idx_w(DEPTH_B),
    localparam int BCW    = cnt_w(DEPTH_B)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [WIDE_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [WIDE_W-1:0] head_o,
    output logic [BCW-1:0]    cnt_o
);
    typedef struct packed {
        logic [DEPTH_B-1:0][WIDE_W-1:0] slot;
        logic [PW-1:0]                  head;
        logic [PW-1:0]                  tail;
        logic [BCW-1:0]                 cnt;
    } pbuf_t;

    pbuf_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.slot[st_q.tail] = push_data_i;
            st_d.tail = (st_q.tail == PW'(DEPTH_B - 1)) ? '0 : st_q.tail + PW'(1);
        end
        if (pop_i) begin
            st_d.head = (st_q.head == PW'(DEPTH_B - 1)) ? '0 : st_q.head + PW'(1);
        end
        case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + BCW'(1);
            2'b01:   st_d.cnt = st_q.cnt - BCW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    assign head_o = st_q.slot[st_q.head];
    assign cnt_o  = st_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: data coming back from memory always finds a free slot
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (int'(st_q.cnt) < DEPTH_B));
    // R9: a word leaves the buffer only if one is held
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (st_q.cnt != '0));
endmodule

// File: rtl/gearbox_fifo.sv
module gearbox_fifo
    import gearbox_pkg::*;
#(
    parameter int WIDE_W   = 32,
    parameter int RATIO    = 4,
    parameter bit UNPACK   = 1'b0,
    parameter int DEPTH    = 8,
    parameter int AF_LEVEL = 2,
    parameter bit MEM_REG  = 1'b0,
    localparam int NW      = WIDE_W / RATIO,
    localparam int IN_W    = UNPACK ? WIDE_W : NW,
    localparam int OUT_W   = UNPACK ? NW : WIDE_W,
    localparam int AW      = idx_w(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [IN_W-1:0]   wr_data,
    input  logic              rd_req,
    output logic [OUT_W-1:0]  rd_data,
    output logic              full,
    output logic              empty,
    output logic              almost_full,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [WIDE_W-1:0] mem_wdata,
    output logic              mem_re,
    output logic [AW-1:0]     mem_raddr,
    input  logic [WIDE_W-1:0] mem_rdata
);
    localparam int CW   = cnt_w(DEPTH);
    localparam int BUFD = MEM_REG ? 4 : 2;
    localparam int BCW  = cnt_w(BUFD);

    typedef struct packed {
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic [CW-1:0]    mcnt;   // written, not yet read from memory
        logic [CW-1:0]    occ;    // entries held, not yet released
        logic [OUT_W-1:0] out;
    } top_t;

    top_t st_q, st_d;

    logic              load_ok, take, commit, pop, pf, rvalid;
    logic [WIDE_W-1:0] word, head, rdata_in;
    logic [OUT_W-1:0]  sel_data;
    logic [BCW-1:0]    buf_cnt;
    logic [1:0]        inflight;

    assign full        = (st_q.occ == CW'(DEPTH));
    assign almost_full = (DEPTH - int'(st_q.occ)) <= AF_LEVEL;
    assign empty       = (buf_cnt == '0);
    assign load_ok     = wr_req && !full;
    assign take        = rd_req && !empty;
    assign pf          = (st_q.mcnt != '0) && ((int'(buf_cnt) + int'(inflight)) < BUFD);
    assign rd_data     = st_q.out;

    if (UNPACK) begin : g_unpack
        assign commit = load_ok;
        assign word   = wr_data;
        gbx_unpack #(.WIDE_W(WIDE_W), .RATIO(RATIO)) u_unpack (
            .clk    (clk),
            .rst_n  (rst_n),
            .take_i (take),
            .head_i (head),
            .pop_o  (pop),
            .lane_o (sel_data)
        );
    end else begin : g_pack
        gbx_pack #(.WIDE_W(WIDE_W), .RATIO(RATIO)) u_pack (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load_ok),
            .data_i   (wr_data),
            .commit_o (commit),
            .word_o   (word)
        );
        assign pop      = take;
        assign sel_data = head;
    end

    gbx_mem_port #(.WIDE_W(WIDE_W), .AW(AW), .MEM_REG(MEM_REG)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (commit),
        .waddr_i    (st_q.wptr),
        .wdata_i    (word),
        .re_i       (pf),
        .raddr_i    (st_q.rptr),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .mem_re     (mem_re),
        .mem_raddr  (mem_raddr),
        .mem_rdata  (mem_rdata),
        .rvalid_o   (rvalid),
        .rdata_o    (rdata_in),
        .inflight_o (inflight)
    );

    gbx_prefetch #(.WIDE_W(WIDE_W), .DEPTH_B(BUFD)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (rvalid),
        .push_data_i (rdata_in),
        .pop_i       (pop),
        .head_o      (head),
        .cnt_o       (buf_cnt)
    );

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.wptr = (st_q.wptr == AW'(DEPTH - 1)) ? '0 : st_q.wptr + AW'(1);
        end
        if (pf) begin
            st_d.rptr = (st_q.rptr == AW'(DEPTH - 1)) ? '0 : st_q.rptr + AW'(1);
        end
        case ({commit, pf})
            2'b10:   st_d.mcnt = st_q.mcnt + CW'(1);
            2'b01:   st_d.mcnt = st_q.mcnt - CW'(1);
            default: st_d.mcnt = st_q.mcnt;
        endcase
        case ({commit, pop})
            2'b10:   st_d.occ = st_q.occ + CW'(1);
            2'b01:   st_d.occ = st_q.occ - CW'(1);
            default: st_d.occ = st_q.occ;
        endcase
        if (take) begin
            st_d.out = sel_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: nothing reaches memory while the queue is full
    a_r8_no_commit_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !commit);
    // R6: occupancy never passes the depth
    a_r6_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.occ) <= DEPTH);
    // R9: an entry is released only while data is ready
    a_r9_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R4: without an accepted extract the output holds
    a_r4_output_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(rd_data));
    // R7: full always implies almost full
    a_r7_af_with_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> almost_full);
endmodule

// File: tb/gearbox_fifo_tb.sv
module gearbox_fifo_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;

    // Packing instance, registered memory path (3-cycle read latency)
    logic        pk_wr_req = 0, pk_rd_req = 0;
    logic [7:0]  pk_wr_data = '0;
    logic [31:0] pk_rd_data;
    logic        pk_full, pk_empty, pk_af;
    logic        pk_mem_we, pk_mem_re;
    logic [2:0]  pk_mem_waddr, pk_mem_raddr;
    logic [31:0] pk_mem_wdata, pk_mem_rdata;
    logic [31:0] pk_ram [8];
    int          pk_wcnt = 0;

    gearbox_fifo #(.WIDE_W(32), .RATIO(4), .UNPACK(1'b0), .DEPTH(8),
                   .AF_LEVEL(2), .MEM_REG(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_req(pk_wr_req), .wr_data(pk_wr_data),
        .rd_req(pk_rd_req), .rd_data(pk_rd_data), .full(pk_full),
        .empty(pk_empty), .almost_full(pk_af), .mem_we(pk_mem_we),
        .mem_waddr(pk_mem_waddr), .mem_wdata(pk_mem_wdata), .mem_re(pk_mem_re),
        .mem_raddr(pk_mem_raddr), .mem_rdata(pk_mem_rdata));

    always @(posedge clk) begin
        if (pk_mem_we) begin
            pk_ram[pk_mem_waddr] <= pk_mem_wdata;
            pk_wcnt <= pk_wcnt + 1;
        end
        if (pk_mem_re) pk_mem_rdata <= pk_ram[pk_mem_raddr];
    end

    // Unpacking instance, direct memory path (1-cycle read latency)
    logic        up_wr_req = 0, up_rd_req = 0;
    logic [31:0] up_wr_data = '0;
    logic [7:0]  up_rd_data;
    logic        up_full, up_empty, up_af;
    logic        up_mem_we, up_mem_re;
    logic [2:0]  up_mem_waddr, up_mem_raddr;
    logic [31:0] up_mem_wdata, up_mem_rdata;
    logic [31:0] up_ram [8];
    int          up_wcnt = 0;
    int          up_last_addr = -1;
    int          up_addr_bad = 0;

    gearbox_fifo #(.WIDE_W(32), .RATIO(4), .UNPACK(1'b1), .DEPTH(8),
                   .AF_LEVEL(2), .MEM_REG(1'b0)) u_unp (
        .clk(clk), .rst_n(rst_n), .wr_req(up_wr_req), .wr_data(up_wr_data),
        .rd_req(up_rd_req), .rd_data(up_rd_data), .full(up_full),
        .empty(up_empty), .almost_full(up_af), .mem_we(up_mem_we),
        .mem_waddr(up_mem_waddr), .mem_wdata(up_mem_wdata), .mem_re(up_mem_re),
        .mem_raddr(up_mem_raddr), .mem_rdata(up_mem_rdata));

    always @(posedge clk) begin
        if (up_mem_we) begin
            up_ram[up_mem_waddr] <= up_mem_wdata;
            up_wcnt <= up_wcnt + 1;
            if (int'(up_mem_waddr) != ((up_last_addr + 1) % 8)) up_addr_bad <= up_addr_bad + 1;
            up_last_addr <= int'(up_mem_waddr);
        end
        if (up_mem_re) up_mem_rdata <= up_ram[up_mem_raddr];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] grp(input int e);
        return {8'(e * 16 + 3), 8'(e * 16 + 2), 8'(e * 16 + 1), 8'(e * 16)};
    endfunction

    task automatic pk_push(input logic [7:0] b);
        pk_wr_data = b; pk_wr_req = 1'b1;
        @(negedge clk);
        pk_wr_req = 1'b0;
    endtask

    task automatic up_push(input logic [31:0] w);
        up_wr_data = w; up_wr_req = 1'b1;
        @(negedge clk);
        up_wr_req = 1'b0;
    endtask

    task automatic pk_pop(output logic [31:0] d);
        int n = 0;
        while (pk_empty && n < 10) begin @(negedge clk); n++; end
        if (pk_empty) check("R10 pack empty stuck", 32'(pk_empty), 32'd0);
        pk_rd_req = 1'b1;
        @(negedge clk);
        pk_rd_req = 1'b0;
        d = pk_rd_data;
    endtask

    task automatic up_pop(output logic [7:0] d);
        int n = 0;
        while (up_empty && n < 10) begin @(negedge clk); n++; end
        if (up_empty) check("R10 unpack empty stuck", 32'(up_empty), 32'd0);
        up_rd_req = 1'b1;
        @(negedge clk);
        up_rd_req = 1'b0;
        d = up_rd_data;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 empty in reset", 32'(pk_empty), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pack empty", 32'(pk_empty), 32'd1);
        check("R1 pack full", 32'(pk_full), 32'd0);
        check("R1 pack almost_full", 32'(pk_af), 32'd0);
        check("R1 unpack empty", 32'(up_empty), 32'd1);
        check("R1 unpack full", 32'(up_full), 32'd0);
        check("R1 unpack almost_full", 32'(up_af), 32'd0);
    endtask

    task automatic t_pack_order();
        logic [31:0] d;
        int w0 = pk_wcnt;
        pk_push(8'hAA); pk_push(8'hBB); pk_push(8'hCC);
        repeat (8) @(negedge clk);
        check("R5 partial group keeps empty", 32'(pk_empty), 32'd1);
        check("R5 partial group no write", 32'(pk_wcnt - w0), 32'd0);
        pk_push(8'hDD);
        pk_pop(d);
        check("R2 R4 packed lane order", d, 32'hDDCCBBAA);
        check("R11 one write per entry", 32'(pk_wcnt - w0), 32'd1);
        repeat (3) @(negedge clk);
        check("R4 output holds without extract", pk_rd_data, 32'hDDCCBBAA);
    endtask

    task automatic t_pack_fill();
        logic [31:0] d;
        int w0 = pk_wcnt;
        for (int e = 0; e < 8; e++) begin
            for (int l = 0; l < 4; l++) pk_push(8'(e * 16 + l));
            check("R7 pack almost_full on fill", 32'(pk_af), 32'((8 - (e + 1)) <= 2));
            check("R6 pack full on fill", 32'(pk_full), 32'(e == 7));
        end
        for (int l = 0; l < 4; l++) pk_push(8'hEE);
        repeat (4) @(negedge clk);
        check("R8 load while full no write", 32'(pk_wcnt - w0), 32'd8);
        check("R8 full unchanged", 32'(pk_full), 32'd1);
        check("R8 almost_full unchanged", 32'(pk_af), 32'd1);
        for (int e = 0; e < 8; e++) begin
            pk_pop(d);
            check("R2 R4 pack drain data", d, grp(e));
            if (e == 0) check("R6 pack full released", 32'(pk_full), 32'd0);
        end
        repeat (8) @(negedge clk);
        check("R8 no stored extra entry", 32'(pk_empty), 32'd1);
        check("R7 almost_full clear when drained", 32'(pk_af), 32'd0);
    endtask

    task automatic t_unpack_order();
        logic [7:0] d;
        up_push(32'h44332211);
        up_pop(d); check("R3 R4 lane 0 first", 32'(d), 32'h11);
        up_pop(d); check("R3 lane 1", 32'(d), 32'h22);
        up_pop(d); check("R3 lane 2", 32'(d), 32'h33);
        check("R6 partial word not empty", 32'(up_empty), 32'd0);
        up_pop(d); check("R3 lane 3", 32'(d), 32'h44);
        check("R6 empty after last lane", 32'(up_empty), 32'd1);
    endtask

    task automatic t_unpack_fill();
        logic [7:0] d;
        int w0 = up_wcnt;
        for (int e = 0; e < 8; e++) begin
            up_push(grp(e));
            check("R7 unpack almost_full on fill", 32'(up_af), 32'((8 - (e + 1)) <= 2));
            check("R6 unpack full on fill", 32'(up_full), 32'(e == 7));
        end
        up_push(32'hDEADBEEF);
        repeat (3) @(negedge clk);
        check("R8 unpack load while full no write", 32'(up_wcnt - w0), 32'd8);
        check("R11 write addresses cyclic", 32'(up_addr_bad), 32'd0);
        for (int e = 0; e < 8; e++) begin
            for (int l = 0; l < 4; l++) begin
                up_pop(d);
                check("R3 R4 unpack drain lane", 32'(d), 32'(8'(e * 16 + l)));
                if (e == 0 && l == 2) check("R6 full held mid-word", 32'(up_full), 32'd1);
                if (e == 0 && l == 3) check("R6 full released on last lane", 32'(up_full), 32'd0);
            end
        end
        repeat (6) @(negedge clk);
        check("R8 unpack no extra entry", 32'(up_empty), 32'd1);
    endtask

    task automatic t_empty_extract();
        logic [31:0] pk_keep = pk_rd_data;
        logic [7:0]  up_keep = up_rd_data;
        pk_rd_req = 1'b1; up_rd_req = 1'b1;
        @(negedge clk);
        pk_rd_req = 1'b0; up_rd_req = 1'b0;
        @(negedge clk);
        check("R9 pack data unchanged", pk_rd_data, pk_keep);
        check("R9 pack still empty", 32'(pk_empty), 32'd1);
        check("R9 unpack data unchanged", 32'(up_rd_data), 32'(up_keep));
        check("R9 unpack flags unchanged", 32'({up_empty, up_full, up_af}), 32'b100);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_pack_order();
        t_pack_fill();
        t_unpack_order();
        t_unpack_fill();
        t_empty_extract();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule